// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A single-clock synchronous static memory whose inputs are all registered on the rising edge and whose read and write commands may follow each other in any order on consecutive clocks with no idle slot between them. A write command carries its address, and its data follows two enabled clocks later. A read returns its word two enabled clocks after the command. Writes are held for one more edge before they reach the storage array. A read that falls in that window is served from the held write, lane by lane.

The word is split into byte lanes, each eight data bits plus one parity bit, with a write enable per lane. A four-beat burst counter steps the two low address bits, in linear or exclusive-or order. The device is selected only by one pattern on three chip-select inputs. A clock-enable input stalls the whole block. An output-enable input acts without the clock. A sleep input freezes the block and keeps its contents.

The data path has no handshake. Clock enable is the only back-pressure: when it is inactive the edge does not exist for the block, and the producer must hold its command and data until an enabled edge. The read word stands on `rdata` while `rdata_en` is high. The separate `wdata` and `rdata` ports and the `rdata_en` flag replace a bidirectional bus and its tri-state driver.

Top module: `zt_sram`

## Requirements
- R1: After reset the block is deselected, `rdata_en` is 0, and `load_n`-high cycles issued before any selected command do nothing.
- R2: A cycle with `load_n`=0 is a selected command only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Every other combination deselects the block, and the data slot two enabled clocks later keeps `rdata_en` at 0.
- R3: A read command (`load_n`=0, selected, `wr_n`=1) sampled at enabled edge k sets `rdata_en` and places the word on `rdata` just after enabled edge k+2. Both hold until the next enabled edge.
- R4: For a write command (`wr_n`=0) sampled at enabled edge k, `wdata` is sampled at enabled edge k+2. Any later read of that address returns it.
- R5: Bit i of `lane_wr_n` at 0 writes only bits [9i+8:9i]. A write with every bit of `lane_wr_n` at 1 changes no stored bit.
- R6: A cycle with `load_n`=1 continues the current burst in the same direction. The n-th continuation (n = 1..3, wrapping after 3) uses the loaded address with its two low bits replaced by (low + n) mod 4 when `linear`=1, and by low XOR n when `linear`=0. Continuing a write burst also samples `lane_wr_n` on that cycle.
- R7: After a deselecting command, `load_n`=1 cycles stay deselected until the next selected `load_n`=0 cycle.
- R8: Reads and writes may alternate on every clock. A read of an address written one command earlier returns the new data, merged by that write's lane enables.
- R9: An edge with `clk_en_n`=1 changes no state and writes nothing. `rdata` and `rdata_en` keep their values across it.
- R10: `oe_n`=1 forces `rdata_en` to 0 at once, without waiting for a clock. The data slot of a write or deselect command never drives.
- R11: While `sleep`=1, `rdata_en` is 0 and all edges are ignored. After `sleep` returns to 0, operation resumes from the preserved array and pipeline contents.
- R12: `sleep` may rise only when neither of the two previous enabled edges sampled a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the edge |
| sel_a_n | input | 1 | Chip select, must be 0 to select |
| sel_b | input | 1 | Chip select, must be 1 to select |
| sel_c_n | input | 1 | Chip select, must be 0 to select |
| load_n | input | 1 | 0 begins a command, 1 continues the burst |
| wr_n | input | 1 | 0 write, 1 read, on a begin cycle |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address on a begin cycle |
| linear | input | 1 | Burst order: 1 linear, 0 exclusive-or |
| wdata | input | LANES*LANE_W | Write data, two enabled clocks after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, contents kept |
| rdata | output | LANES*LANE_W | Read data |
| rdata_en | output | 1 | High while `rdata` is driven |

## Verification
The bench builds the block with a 4-bit address (16 words) and two 9-bit lanes. That size lets every address be written and read back in full, and every lane mask, including the abort mask, be applied at every address. Every burst start offset is run in both orders, with the four-beat wrap landing at each position. A long seeded mix of alternating reads and writes with stalls, deselects and output-enable changes reaches the held-write forwarding path many times. A sleep interval that carries ignored write attempts checks that the contents survive.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_n,
  input  logic              selected,
  input  logic              wr_n,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, nxt_cnt, cont_low;
  logic [ADDR_W-1:0]  cont_addr;
  op_e                dir_q, begin_op;

  assign nxt_cnt  = cnt_q + 1'b1;
  assign cont_low = linear ? (base_q[BURST_W-1:0] + nxt_cnt)
                           : (base_q[BURST_W-1:0] ^ nxt_cnt);

  generate
    if (ADDR_W > BURST_W) begin : g_wide
      assign cont_addr = {base_q[ADDR_W-1:BURST_W], cont_low};
    end else begin : g_narrow
      assign cont_addr = cont_low;
    end
  endgenerate

  assign begin_op = selected ? (wr_n ? OP_READ : OP_WRITE) : OP_NONE;

  always_comb begin
    if (!load_n) begin
      cmd_op   = begin_op;
      cmd_addr = addr_in;
    end else begin
      cmd_op   = dir_q;
      cmd_addr = cont_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      dir_q  <= OP_NONE;
    end else if (step) begin
      if (!load_n) begin
        base_q <= addr_in;
        cnt_q  <= '0;
        dir_q  <= begin_op;
      end else begin
        cnt_q  <= nxt_cnt;
      end
    end
  end

  AST_DESEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_n && !selected) |=> (!load_n || cmd_op == OP_NONE)); // R7
endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_bw,
  output op_e               head_op,
  output op_e               tail_op,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [LANES-1:0]  tail_bw
);
  op_e               op_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LANES-1:0]  bw_q   [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]   <= OP_NONE;
        addr_q[i] <= '0;
        bw_q[i]   <= '0;
      end
    end else if (step) begin
      for (int i = DEPTH-1; i > 0; i--) begin
        op_q[i]   <= op_q[i-1];
        addr_q[i] <= addr_q[i-1];
        bw_q[i]   <= bw_q[i-1];
      end
      op_q[0]   <= in_op;
      addr_q[0] <= in_addr;
      bw_q[0]   <= in_bw;
    end
  end

  assign head_op   = op_q[0];
  assign tail_op   = op_q[DEPTH-1];
  assign tail_addr = addr_q[DEPTH-1];
  assign tail_bw   = bw_q[DEPTH-1];
endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  op_e                     op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_vld
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LANES-1:0]  pend_bw;
  logic              pend_hit;
  logic [DATA_W-1:0] array_word, merged;

  assign pend_hit   = pend_vld && (pend_addr == addr);
  assign array_word = mem[addr];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] = (pend_hit && pend_bw[g])
        ? pend_data[g*LANE_W +: LANE_W] : array_word[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (step && pend_vld) begin
      for (int i = 0; i < LANES; i++) begin
        if (pend_bw[i]) mem[pend_addr][i*LANE_W +: LANE_W] <= pend_data[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_bw   <= '0;
      rdata     <= '0;
      rd_vld    <= 1'b0;
    end else if (step) begin
      pend_vld <= (op == OP_WRITE);
      rd_vld   <= (op == OP_READ);
      if (op == OP_WRITE) begin
        pend_addr <= addr;
        pend_data <= wdata;
        pend_bw   <= bw;
      end
      if (op == OP_READ) rdata <= merged;
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(rdata) && $stable(rd_vld))); // R9
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    linear,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en
);
  localparam int STAGES = 2;

  logic              step, selected, rd_vld;
  op_e               cmd_op, s1_op, s2_op;
  logic [ADDR_W-1:0] cmd_addr, s2_addr;
  logic [LANES-1:0]  s2_bw;

  assign step     = !clk_en_n && !sleep;
  assign selected = !sel_a_n && sel_b && !sel_c_n;

  zt_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .step(step), .load_n(load_n),
    .selected(selected), .wr_n(wr_n), .linear(linear), .addr_in(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  zt_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .step(step), .in_op(cmd_op),
    .in_addr(cmd_addr), .in_bw(~lane_wr_n), .head_op(s1_op),
    .tail_op(s2_op), .tail_addr(s2_addr), .tail_bw(s2_bw)
  );

  zt_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .step(step), .op(s2_op), .addr(s2_addr),
    .bw(s2_bw), .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld)
  );

  assign rdata_en = rd_vld && !oe_n && !sleep;

  AST_READ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s2_op == OP_READ) |=> rd_vld); // R3
  AST_NONREAD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s2_op != OP_READ) |=> !rdata_en); // R10
  AST_SLEEP_ENTRY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> (s1_op != OP_WRITE && s2_op != OP_WRITE)); // R12
  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(s2_op) && $stable(s2_addr) && $stable(rd_vld))); // R11
endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          load_n = 1'b0, wr_n = 1'b1, linear = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_en;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .load_n(load_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .linear(linear), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdata_en(rdata_en)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference state
  logic [DW-1:0] ref_mem [WORDS];
  int            h_op   [2];  // 0 none, 1 read, 2 write; [0]=previous edge, [1]=two edges back
  logic [AW-1:0] h_addr [2];
  logic [LN-1:0] h_bw   [2];
  logic [DW-1:0] h_data [2];
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  int            b_op;
  bit            exp_rd;
  logic [DW-1:0] exp_dout;
  int            nvec = 0, nfail = 0;
  string         cur_req = "R1";
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // One clock: sel_code 0 selects, any other value deselects.
  task automatic tick(input bit stall, input bit sl, input bit ldn, input logic [2:0] sel_code,
                      input bit wrn, input logic [LN-1:0] bwn, input logic [AW-1:0] a,
                      input bit oen, input bit lin, input logic [DW-1:0] wd);
    int            c_op;
    logic [AW-1:0] c_addr;
    logic [1:0]    n;
    bit            en, exp_en;
    clk_en_n = stall; sleep = sl; load_n = ldn;
    sel_a_n = sel_code[0]; sel_b = ~sel_code[1]; sel_c_n = sel_code[2];
    wr_n = wrn; lane_wr_n = bwn; addr = a; oe_n = oen; linear = lin;
    wdata = (h_op[1] == 2) ? h_data[1] : DW'(rnd());
    if (!ldn) begin
      c_op = (sel_code != 3'd0) ? 0 : (wrn ? 1 : 2);
      c_addr = a;
    end else begin
      c_op = b_op;
      n = b_cnt + 2'd1;
      c_addr = {b_base[AW-1:2], lin ? (b_base[1:0] + n) : (b_base[1:0] ^ n)};
    end
    @(posedge clk); #1;
    en = !stall && !sl;
    if (en) begin
      if (h_op[1] == 2) begin
        for (int i = 0; i < LN; i++)
          if (h_bw[1][i]) ref_mem[h_addr[1]][i*LW +: LW] = h_data[1][i*LW +: LW];
      end
      exp_rd = (h_op[1] == 1);
      if (exp_rd) exp_dout = ref_mem[h_addr[1]];
      h_op[1] = h_op[0]; h_addr[1] = h_addr[0]; h_bw[1] = h_bw[0]; h_data[1] = h_data[0];
      h_op[0] = c_op; h_addr[0] = c_addr; h_bw[0] = ~bwn; h_data[0] = wd;
      if (!ldn) begin b_base = a; b_cnt = 2'd0; b_op = c_op; end
      else b_cnt = b_cnt + 2'd1;
    end
    exp_en = exp_rd && !oen && !sl;
    check(rdata_en == exp_en, "rdata_en", DW'(rdata_en), DW'(exp_en));
    if (exp_en) check(rdata == exp_dout, "rdata", rdata, exp_dout);
  endtask

  task automatic desel(input int k);
    for (int i = 0; i < k; i++) tick(0, 0, 0, 3'd1, 1, '1, '0, 0, 1, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    for (int i = 0; i < 2; i++) begin h_op[i] = 0; h_addr[i] = '0; h_bw[i] = '0; h_data[i] = '0; end
    b_base = '0; b_cnt = '0; b_op = 0; exp_rd = 0; exp_dout = '0;
    // R1: reset state, then continue cycles before any command
    repeat (3) @(posedge clk);
    #1; cur_req = "R1";
    check(rdata_en == 1'b0, "rdata_en in reset", DW'(rdata_en), '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 3'd0, 0, '0, AW'(i), 0, 1, DW'(i));
    // R4: fill every word, then read all back
    cur_req = "R4";
    for (int a = 0; a < WORDS; a++) tick(0, 0, 0, 3'd0, 0, 2'b00, AW'(a), 0, 1, DW'(a * 4909 + 77));
    desel(2);
    for (int a = 0; a < WORDS; a++) tick(0, 0, 0, 3'd0, 1, '1, AW'(a), 0, 1, '0);
    desel(3);
    // R5: every lane mask including abort, at every address
    cur_req = "R5";
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < WORDS; a++) tick(0, 0, 0, 3'd0, 0, LN'(m), AW'(a), 0, 1, DW'(rnd()));
      desel(2);
      for (int a = 0; a < WORDS; a++) tick(0, 0, 0, 3'd0, 1, '1, AW'(a), 0, 1, '0);
      desel(2);
    end
    // R6: bursts in both orders from every start offset
    cur_req = "R6";
    for (int l = 0; l < 2; l++) begin
      for (int s = 0; s < 4; s++) begin
        tick(0, 0, 0, 3'd0, 0, 2'b00, AW'(8 + s), 0, l[0], DW'(rnd()));
        for (int b = 0; b < 3; b++) tick(0, 0, 1, 3'd0, 0, LN'(b), '0, 0, l[0], DW'(rnd()));
        tick(0, 0, 0, 3'd0, 1, '1, AW'(8 + s), 0, l[0], '0);
        for (int b = 0; b < 5; b++) tick(0, 0, 1, 3'd0, 1, '1, '0, 0, l[0], '0);
        desel(2);
      end
    end
    // R8: write then read the same word on the next clock, alternating
    cur_req = "R8";
    for (int a = 0; a < WORDS; a++) begin
      tick(0, 0, 0, 3'd0, 0, LN'(a % 3), AW'(a), 0, 1, DW'(rnd()));
      tick(0, 0, 0, 3'd0, 1, '1, AW'(a), 0, 1, '0);
    end
    desel(2);
    // R2 R7: every non-selecting pattern, followed by continue cycles
    cur_req = "R2 R7";
    for (int p = 1; p < 8; p++) begin
      tick(0, 0, 0, 3'd0, 1, '1, AW'(p), 0, 1, '0);
      tick(0, 0, 0, 3'(p), 1, '1, AW'(p), 0, 1, '0);
      for (int k = 0; k < 3; k++) tick(0, 0, 1, 3'(p), 0, '0, '0, 0, 1, DW'(rnd()));
    end
    desel(2);
    // R8 R9 R10: seeded mix with stalls, deselects and output-enable changes
    cur_req = "R8 R9 R10";
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < 2000; i++) begin
        logic [31:0] r;
        r = rnd();
        tick(r[2:0] == 3'd0, 0, r[5:4] == 2'd0, (r[9:7] == 3'd0) ? 3'(r[12:10]) : 3'd0,
             r[13], LN'(r[15:14]), AW'(r[19:16]), r[22:20] == 3'd0, l[0], DW'(rnd()));
      end
      desel(2);
    end
    // R11 R12: two non-write edges, sleep with ignored commands, resume
    cur_req = "R11 R12";
    desel(2);
    for (int i = 0; i < 10; i++) tick(0, 1, 0, 3'd0, 0, 2'b00, AW'(i), 0, 1, DW'(rnd()));
    for (int a = 0; a < WORDS; a++) tick(0, 0, 0, 3'd0, 1, '1, AW'(a), 0, 1, '0);
    desel(3);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule